// File: doc/BRIEF.md
# Four-Pin GPIO Register Bank with Input Polarity Control

This block holds the four port registers of a small general-purpose I/O expander. A register-access front end drives it through a 2-bit register select, a write strobe with an 8-bit write-data bus, and a read strobe. Read data comes back on an 8-bit bus that is captured at the read strobe edge and then held. On the pin side the block drives four output values, each with its own output enable, and samples four pin inputs through a two-flop synchroniser.

The four registers are the input view, the output latch, the polarity-inversion mask and the direction mask. Only the low nibble of each register is stored. The upper nibble always reads back as the reset fill of its register.

A small access controller turns the two strobes into one operation per cycle. It has three states:
- `ACC_IDLE`: no strobe is high.
- `ACC_WRITE`: entered whenever `wr_stb` is high, even if `rd_stb` is also high.
- `ACC_READ`: entered when only `rd_stb` is high.

Every state can move to any state on the next edge. The chosen operation is carried out on the same edge that enters the state.

Top module: `gpio_polarity_bank`

## Requirements
- R1: Register select codes are 0 = input view, 1 = output latch, 2 = polarity mask, 3 = direction mask. A read strobe sampled on a clock edge loads `rd_data` with the selected register on that edge.
- R2: After reset:
  - reading select 1 returns 0xFF, select 2 returns 0x00 and select 3 returns 0xFF;
  - `pin_oe` is 0000, `pin_out` is 0000 and `rd_data` is 0x00.
- R3: Direction bit i = 1 makes pin i an input (`pin_oe[i]` = 0). Direction bit i = 0 makes pin i an output (`pin_oe[i]` = 1). A write to select 3 shows on `pin_oe` in the cycle after the write strobe.
- R4: When `pin_oe[i]` = 1, `pin_out[i]` equals output-latch bit i. When `pin_oe[i]` = 0, `pin_out[i]` is 0, so the output latch has no effect on input pins.
- R5: Reading select 0 returns 1111 in bits 7:4. Bits 3:0 are the synchronised pin level XOR the polarity mask, whatever the pin direction.
- R6: A pin change made before clock edge k is seen by a read strobe sampled at edge k+2 or later. A read strobe at edge k or k+1 still returns the old level.
- R7: A write to select 0 changes no register and no pin output.
- R8: Bits 7:4 of writes to selects 1, 2 and 3 are ignored. These bits read back as the reset fill: 1111, 0000 and 1111 respectively.
- R9: Reading select 1 returns the stored latch value, not the pin level.
- R10: When `wr_stb` and `rd_stb` are high in the same cycle, the write is done and the read is dropped, so `rd_data` keeps its value.
- R11: `rd_data` holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe, captures read data at the edge |
| rd_data | output | 8 | Captured read data |
| pin_in | input | 4 | Pin levels, asynchronous |
| pin_out | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables, 1 = drive |

## Verification
Corruption in the direction or output latch shows on `pin_oe` or `pin_out` in the cycle after the write that set it, so both are compared on every cycle of a full sweep over direction and latch values. A wrong polarity mask or a wrong synchroniser depth appears only through the input view, so every pin pattern is swept against every mask. The pin-change timing is checked edge by edge. A controller that lets a read slip past a write shows as a changed `rd_data` one cycle after the colliding strobes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    typedef enum logic [1:0] {
        SEL_INPUT  = 2'd0,
        SEL_OUTPUT = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_state_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // One flop chain per pin; the last stage feeds the register bank.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/gpio_access_fsm.sv
module gpio_access_fsm
    import gpio_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       rd_stb,
    output logic       wr_en,
    output logic       rd_en,
    output acc_state_e last_op
);
    acc_state_e state_q, state_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_nx;
    end

    // Next state: a write always wins over a read in the same cycle.
    always_comb begin
        state_nx = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_WRITE, ACC_READ: begin
                if (wr_stb)      state_nx = ACC_WRITE;
                else if (rd_stb) state_nx = ACC_READ;
                else             state_nx = ACC_IDLE;
            end
            default: state_nx = ACC_IDLE;
        endcase
    end

    // Outputs: the operation of the state being entered runs on this edge.
    always_comb begin
        wr_en = 1'b0;
        rd_en = 1'b0;
        unique case (state_nx)
            ACC_WRITE: wr_en = 1'b1;
            ACC_READ:  rd_en = 1'b1;
            default: ;
        endcase
    end

    assign last_op = state_q;
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    input  logic             rd_en,
    input  logic [NPINS-1:0] pins_sync,
    output logic [DW-1:0]    rdata,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] dir_q
);
    localparam int FILL_W = DW - NPINS;
    localparam logic [FILL_W-1:0] FILL_ONE  = '1;
    localparam logic [FILL_W-1:0] FILL_ZERO = '0;

    logic [NPINS-1:0] inv_q;
    logic [DW-1:0]    rd_mux;
    reg_sel_e         sel_e;
    logic             unused_wdata_hi;

    assign sel_e           = reg_sel_e'(sel);
    assign unused_wdata_hi = ^wdata[DW-1:NPINS];

    // Only the low nibble of each register is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            inv_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            unique case (sel_e)
                SEL_OUTPUT: out_q <= wdata[NPINS-1:0];
                SEL_INVERT: inv_q <= wdata[NPINS-1:0];
                SEL_DIR:    dir_q <= wdata[NPINS-1:0];
                SEL_INPUT:  ;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel_e)
            SEL_INPUT:  rd_mux = {FILL_ONE,  pins_sync ^ inv_q};
            SEL_OUTPUT: rd_mux = {FILL_ONE,  out_q};
            SEL_INVERT: rd_mux = {FILL_ZERO, inv_q};
            SEL_DIR:    rd_mux = {FILL_ONE,  dir_q};
            default:    rd_mux = '0;
        endcase
    end

    // Read data is captured on the strobe edge and then held.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_polarity_bank.sv
module gpio_polarity_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             wr_stb,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_stb,
    output logic [DW-1:0]    rd_data,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    logic             wr_en, rd_en;
    logic [NPINS-1:0] pins_sync, out_q, dir_q;
    acc_state_e       last_op;

    gpio_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pins_sync)
    );

    gpio_access_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .last_op (last_op)
    );

    gpio_reg_file #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (reg_sel),
        .wr_en     (wr_en),
        .wdata     (wr_data),
        .rd_en     (rd_en),
        .pins_sync (pins_sync),
        .rdata     (rd_data),
        .out_q     (out_q),
        .dir_q     (dir_q)
    );

    // Direction resolution: input pins are not driven and carry 0.
    assign pin_oe  = ~dir_q;
    assign pin_out = out_q & ~dir_q;
endmodule

// File: rtl/gpio_polarity_bank_chk.sv
module gpio_polarity_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_sel,
    input logic             wr_stb,
    input logic [DW-1:0]    wr_data,
    input logic             rd_stb,
    input logic [DW-1:0]    rd_data,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input acc_state_e       last_op
);
    assert_dir_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_sel == 2'd3) |=> (pin_oe == ~$past(wr_data[NPINS-1:0])));

    assert_out_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_sel == 2'd1) |=> ((pin_out & pin_oe) == ($past(wr_data[NPINS-1:0]) & pin_oe)));

    assert_input_pins_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    assert_input_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && reg_sel == 2'd0) |=> (rd_data[DW-1:NPINS] == '1));

    assert_reg0_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && reg_sel == 2'd0) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_output_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && reg_sel == 2'd1) |=> (rd_data[DW-1:NPINS] == '1));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb) |=> (last_op == ACC_WRITE && $stable(rd_data)));

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb) |=> $stable(rd_data));
endmodule

bind gpio_polarity_bank gpio_polarity_bank_chk #(.NPINS(NPINS), .DW(DW)) u_chk (.*);

// File: tb/gpio_polarity_bank_test.sv
`timescale 1ns/1ps
module gpio_polarity_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] pin_in = 4'h0;
    logic [3:0] pin_out, pin_oe;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_polarity_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 rd_data", rd_data, 8'h00);
        chk("R2 pin_oe", {4'h0, pin_oe}, 8'h00);
        chk("R2 pin_out", {4'h0, pin_out}, 8'h00);
        rd(2'd1, v); chk("R2 output latch", v, 8'hFF);
        rd(2'd2, v); chk("R2 polarity", v, 8'h00);
        rd(2'd3, v); chk("R2 direction", v, 8'hFF);

        // R1 R5: all pins as inputs, every pin pattern against every mask
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                pin_in = p[3:0];
                wr(2'd2, {4'h0, m[3:0]});
                repeat (3) @(negedge clk);
                rd(2'd0, v);
                chk("R5 input view", v, {4'hF, p[3:0] ^ m[3:0]});
            end
        end

        // R5: the input view follows the pins even when they are outputs
        wr(2'd3, 8'h00);
        pin_in = 4'hC;
        wr(2'd2, 8'h03);
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R5 output pins still read", v, 8'hFF);

        // R3 R4 R1: sweep over direction and latch values
        for (int c = 0; c < 16; c++) begin
            for (int o = 0; o < 16; o++) begin
                wr(2'd1, {4'h0, o[3:0]});
                wr(2'd3, {4'h0, c[3:0]});
                chk("R3 pin_oe", {4'h0, pin_oe}, {4'h0, ~c[3:0]});
                chk("R4 pin_out", {4'h0, pin_out}, {4'h0, o[3:0] & ~c[3:0]});
                rd(2'd1, v); chk("R1 output latch read", v, {4'hF, o[3:0]});
                rd(2'd3, v); chk("R1 direction read", v, {4'hF, c[3:0]});
            end
        end

        // R6: the pin change is seen two edges after the first edge
        wr(2'd2, 8'h00);
        wr(2'd3, 8'hFF);
        pin_in = 4'h0;
        repeat (4) @(negedge clk);
        reg_sel = 2'd0; rd_stb = 1'b1; pin_in = 4'hF;
        @(negedge clk); chk("R6 edge k", rd_data, 8'hF0);
        @(negedge clk); chk("R6 edge k+1", rd_data, 8'hF0);
        @(negedge clk); chk("R6 edge k+2", rd_data, 8'hFF);
        rd_stb = 1'b0;

        // R7: a write to select 0 is ignored
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h05);
        wr(2'd0, 8'hAA);
        chk("R7 pin_out", {4'h0, pin_out}, 8'h05);
        chk("R7 pin_oe", {4'h0, pin_oe}, 8'h0F);
        rd(2'd1, v); chk("R7 latch", v, 8'hF5);
        rd(2'd3, v); chk("R7 direction", v, 8'hF0);

        // R8: upper nibble of writes ignored
        wr(2'd2, 8'hA5);
        rd(2'd2, v); chk("R8 polarity fill", v, 8'h05);
        wr(2'd1, 8'h3C);
        rd(2'd1, v); chk("R8 latch fill", v, 8'hFC);
        wr(2'd3, 8'h06);
        rd(2'd3, v); chk("R8 direction fill", v, 8'hF6);
        wr(2'd2, 8'h00);

        // R9: latch read is not the pin level
        wr(2'd3, 8'hFF);
        wr(2'd1, 8'h0A);
        pin_in = 4'h5;
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R9 latch not pins", v, 8'hFA);
        chk("R9 pins undriven", {4'h0, pin_out}, 8'h00);

        // R10: colliding strobes, write wins, read dropped
        rd(2'd3, held);
        @(negedge clk);
        reg_sel = 2'd1; wr_data = 8'h03; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        chk("R10 read dropped", rd_data, held);
        rd(2'd1, v); chk("R10 write done", v, 8'hF3);

        // R11: rd_data holds through idle cycles and writes
        held = rd_data;
        wr(2'd2, 8'h0F);
        repeat (5) @(negedge clk);
        pin_in = 4'hA;
        chk("R11 hold", rd_data, held);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule